// File: doc/BRIEF.md
# Continuous Pair-Program Controller

This block is the device-side command engine of a serial flash that supports a continuous program mode. A host sends one frame that holds the mode opcode, a 24-bit start address and two data bytes. The controller then issues one program request for the aligned byte pair at that address and enters the mode. While the mode is active, each later frame holds only the opcode and two data bytes, and the controller programs the next pair up. The write-enable latch and an address protection boundary decide whether a frame is accepted. A single-byte write-disable command leaves the mode. The mode also ends by itself once the pair just below the protected region has been programmed.

Frames arrive on SPI mode-0 pins, which are synchronised into the system clock. Every frame is evaluated when chip-select returns high. The storage array is outside the block. The block only emits a one-cycle program request with an address and a 16-bit data word, and it models the array's busy time as a fixed count of cycles. The host can choose to have the serial output line report ready or busy while the mode is active, instead of returning status bytes.

Top module: `cpm_ctrl`

## Requirements
- R1: After reset, st_wel, st_wip, st_cp, st_rb_en, pgm_valid and spi_miso_oe are all 0.
- R2: Opcode 0x06 sets st_wel. Opcode 0xAD outside the mode starts it only while st_wel=1. The frame carries three address bytes, most significant first, followed by data bytes sent MSB first. It produces one pgm_valid pulse with pgm_addr equal to the address with bit 0 cleared, and pgm_data[15:8] holding the first data byte (even address) and pgm_data[7:0] the second (odd address). It then sets st_cp. Without st_wel the frame has no effect.
- R3: A 0xAD frame with fewer than two data bytes programs nothing and changes no state. Data bytes after the second are ignored.
- R4: A pair whose odd address is at or above prot_base is protected. A 0xAD frame aimed at it is ignored, leaves st_wel unchanged and does not enter the mode.
- R5: Inside the mode, a 0xAD frame carries only two data bytes and programs the pair 2 above the previous one.
- R6: There is no wrap-around. If the pair after the one just programmed would be protected or would exceed the address space, st_cp and st_wel both clear.
- R7: Inside the mode, only opcodes 0xAD, 0x04, 0x05 and 0x2B take effect. Opcodes 0x06, 0x70 and 0x80 are ignored there.
- R8: Opcode 0x04 clears st_wel and st_cp. It takes effect only when st_wip=0.
- R9: Each program request raises st_wip for BUSY_CYC cycles. A frame that ends while st_wip=1 changes nothing and requests no program.
- R10: After opcode 0x05, spi_miso returns {6'b0, wel, wip} MSB first, starting at the falling SCK edge that ends the opcode. After 0x2B it returns a byte whose bit 4 is the mode flag and whose other bits are 0.
- R11: Opcode 0x70 sets st_rb_en and opcode 0x80 clears it, both only outside the mode. While the mode is active and st_rb_en=1, chip-select low drives spi_miso_oe=1 and spi_miso = not-busy. spi_miso_oe is 0 whenever chip-select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | SPI chip-select, active low |
| spi_sck | input | 1 | SPI clock (mode 0) |
| spi_mosi | input | 1 | SPI data in |
| spi_miso | output | 1 | SPI data out |
| spi_miso_oe | output | 1 | Output enable for spi_miso (0 = high impedance) |
| prot_base | input | ADDR_W | Lowest protected address |
| pgm_valid | output | 1 | One-cycle program request |
| pgm_addr | output | ADDR_W | Even address of the pair to program |
| pgm_data | output | 16 | Pair data, even byte in [15:8] |
| st_wel | output | 1 | Write-enable latch |
| st_wip | output | 1 | Program in progress |
| st_cp | output | 1 | Continuous program mode active |
| st_rb_en | output | 1 | Ready/busy output selected |

## Verification
A wrong pair counter shows up on pgm_addr at the first continuation frame after entry, about 5 cycles after chip-select rises. A wrong exit decision shows up at the boundary pair as st_cp or st_wel staying high. A stuck or short busy timer shows up as a continuation frame being accepted or refused contrary to the busy window, and a status read taken inside that window also exposes it. Output-enable faults are visible within a handful of cycles of any chip-select change.

// File: rtl/cpm_pkg.sv
package cpm_pkg;
  localparam logic [7:0] OP_CP    = 8'hAD;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_RDSEC = 8'h2B;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_RBEN  = 8'h70;
  localparam logic [7:0] OP_RBDIS = 8'h80;

  typedef enum logic {M_IDLE, M_CONT} mode_e;

  function automatic logic [7:0] status_byte(input logic wel, input logic wip);
    return {6'b0, wel, wip};
  endfunction

  function automatic logic [7:0] secure_byte(input logic cp);
    return {3'b0, cp, 4'b0};
  endfunction
endpackage

// File: rtl/cpm_spi_rx.sv
module cpm_spi_rx #(
  parameter int SYNC_W = 2,
  parameter int MAXB   = 6,
  localparam int NBW   = $clog2(MAXB + 2)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cs_n,
  input  logic                 sck,
  input  logic                 mosi,
  output logic                 cs_low,
  output logic                 sck_fall,
  output logic                 cs_end,
  output logic                 op_done,
  output logic [7:0]           opcode,
  output logic [MAXB-1:0][7:0] cap,
  output logic [NBW-1:0]       nbytes
);
  localparam logic [NBW-1:0] NB_MAX = NBW'(MAXB + 1);

  logic [SYNC_W-1:0] cs_sy, sck_sy, mo_sy;
  logic cs_s, sck_s, mo_s, cs_q, sck_q;
  logic [6:0] sh;
  logic [2:0] bitc;
  logic cs_fall_det, sck_rise_det, byte_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_sy  <= '1;
      sck_sy <= '0;
      mo_sy  <= '0;
    end else begin
      cs_sy  <= {cs_sy[SYNC_W-2:0], cs_n};
      sck_sy <= {sck_sy[SYNC_W-2:0], sck};
      mo_sy  <= {mo_sy[SYNC_W-2:0], mosi};
    end
  end

  assign cs_s  = cs_sy[SYNC_W-1];
  assign sck_s = sck_sy[SYNC_W-1];
  assign mo_s  = mo_sy[SYNC_W-1];

  assign cs_fall_det  = !cs_s && cs_q;
  assign sck_rise_det = !cs_s && sck_s && !sck_q;
  assign byte_done    = sck_rise_det && (bitc == 3'd7) && !cs_fall_det;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q     <= 1'b1;
      sck_q    <= 1'b0;
      cs_low   <= 1'b0;
      sck_fall <= 1'b0;
      cs_end   <= 1'b0;
      op_done  <= 1'b0;
      sh       <= '0;
      bitc     <= '0;
      nbytes   <= '0;
    end else begin
      cs_q     <= cs_s;
      sck_q    <= sck_s;
      cs_low   <= !cs_s;
      sck_fall <= !cs_s && !sck_s && sck_q;
      cs_end   <= cs_s && !cs_q;
      op_done  <= byte_done && (nbytes == '0);
      if (cs_fall_det) begin
        bitc   <= '0;
        nbytes <= '0;
      end else if (sck_rise_det) begin
        sh   <= {sh[5:0], mo_s};
        bitc <= bitc + 3'd1;
        if (byte_done && nbytes != NB_MAX) nbytes <= nbytes + NBW'(1);
      end
    end
  end

  for (genvar g = 0; g < MAXB; g++) begin : g_cap
    always_ff @(posedge clk) begin
      if (rst) cap[g] <= '0;
      else if (byte_done && nbytes == NBW'(g)) cap[g] <= {sh, mo_s};
    end
  end

  assign opcode = cap[0];
endmodule

// File: rtl/cpm_busy_timer.sv
module cpm_busy_timer #(
  parameter int BUSY_CYC = 256,
  localparam int CW = $clog2(BUSY_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (start) begin
      cnt  <= CW'(BUSY_CYC);
      busy <= 1'b1;
    end else if (cnt != '0) begin
      cnt <= cnt - CW'(1);
      if (cnt == CW'(1)) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/cpm_cmd_fsm.sv
module cpm_cmd_fsm import cpm_pkg::*; #(
  parameter int ADDR_W = 24,
  parameter int MAXB   = 6,
  localparam int NBW   = $clog2(MAXB + 2)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cs_end,
  input  logic [7:0]           opcode,
  input  logic [MAXB-1:0][7:0] cap,
  input  logic [NBW-1:0]       nbytes,
  input  logic                 wip,
  input  logic [ADDR_W-1:0]    prot_base,
  output logic                 wel,
  output logic                 cp,
  output logic                 rb_en,
  output logic                 pgm_valid,
  output logic [ADDR_W-1:0]    pgm_addr,
  output logic [15:0]          pgm_data
);
  localparam logic [NBW-1:0] NB_ENTRY = NBW'(6);
  localparam logic [NBW-1:0] NB_CONT  = NBW'(3);

  mode_e mode, n_mode;
  logic [ADDR_W-1:0] cur, n_cur, tgt;
  logic [23:0] raw_addr;
  logic [15:0] dat;
  logic [ADDR_W:0] odd_ext, nxt_odd;
  logic n_wel, n_rb, go, ok, in_cp, prot_hit, last;

  assign raw_addr = {cap[1], cap[2], cap[3]};
  assign in_cp    = (mode == M_CONT);

  always_comb begin
    if (in_cp) begin
      tgt = cur;
      dat = {cap[1], cap[2]};
      ok  = (nbytes >= NB_CONT);
    end else begin
      tgt = {raw_addr[ADDR_W-1:1], 1'b0};
      dat = {cap[4], cap[5]};
      ok  = wel && (nbytes >= NB_ENTRY);
    end
    odd_ext  = {1'b0, tgt} + (ADDR_W+1)'(1);
    nxt_odd  = {1'b0, tgt} + (ADDR_W+1)'(3);
    prot_hit = (odd_ext >= {1'b0, prot_base});
    last     = nxt_odd[ADDR_W] || (nxt_odd >= {1'b0, prot_base});
  end

  always_comb begin
    n_wel  = wel;
    n_mode = mode;
    n_rb   = rb_en;
    n_cur  = cur;
    go     = 1'b0;
    if (cs_end && !wip && nbytes != '0) begin
      unique case (opcode)
        OP_CP: begin
          if (ok && !prot_hit) begin
            go    = 1'b1;
            n_cur = tgt + ADDR_W'(2);
            if (last) begin
              n_mode = M_IDLE;
              n_wel  = 1'b0;
            end else begin
              n_mode = M_CONT;
            end
          end
        end
        OP_WRDI: begin
          n_wel  = 1'b0;
          n_mode = M_IDLE;
        end
        OP_WREN:  if (!in_cp) n_wel = 1'b1;
        OP_RBEN:  if (!in_cp) n_rb = 1'b1;
        OP_RBDIS: if (!in_cp) n_rb = 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode      <= M_IDLE;
      wel       <= 1'b0;
      rb_en     <= 1'b0;
      cur       <= '0;
      pgm_valid <= 1'b0;
      pgm_addr  <= '0;
      pgm_data  <= '0;
    end else begin
      mode      <= n_mode;
      wel       <= n_wel;
      rb_en     <= n_rb;
      cur       <= n_cur;
      pgm_valid <= go;
      if (go) begin
        pgm_addr <= tgt;
        pgm_data <= dat;
      end
    end
  end

  assign cp = in_cp;
endmodule

// File: rtl/cpm_sdo_drv.sv
module cpm_sdo_drv import cpm_pkg::*; (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_low,
  input  logic       sck_fall,
  input  logic       op_done,
  input  logic [7:0] opcode,
  input  logic       wel,
  input  logic       wip,
  input  logic       cp,
  input  logic       rb_en,
  output logic       miso,
  output logic       miso_oe
);
  logic [7:0] sh;
  logic rd_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      miso    <= 1'b0;
      miso_oe <= 1'b0;
      rd_act  <= 1'b0;
      sh      <= '0;
    end else if (!cs_low) begin
      miso    <= 1'b0;
      miso_oe <= 1'b0;
      rd_act  <= 1'b0;
    end else if (cp && rb_en) begin
      miso_oe <= 1'b1;
      miso    <= !wip;
    end else if (op_done) begin
      rd_act <= (opcode == OP_RDSR) || (opcode == OP_RDSEC);
      sh     <= (opcode == OP_RDSR) ? status_byte(wel, wip) : secure_byte(cp);
    end else if (rd_act && sck_fall) begin
      miso_oe <= 1'b1;
      miso    <= sh[7];
      sh      <= {sh[6:0], sh[7]};
    end
  end
endmodule

// File: rtl/cpm_ctrl.sv
module cpm_ctrl import cpm_pkg::*; #(
  parameter int ADDR_W   = 24,
  parameter int BUSY_CYC = 256,
  parameter int SYNC_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_cs_n,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  input  logic [ADDR_W-1:0] prot_base,
  output logic              pgm_valid,
  output logic [ADDR_W-1:0] pgm_addr,
  output logic [15:0]       pgm_data,
  output logic              st_wel,
  output logic              st_wip,
  output logic              st_cp,
  output logic              st_rb_en
);
  localparam int MAXB = 6;
  localparam int NBW  = $clog2(MAXB + 2);

  logic cs_low, sck_fall, cs_end, op_done;
  logic [7:0] opcode;
  logic [MAXB-1:0][7:0] cap;
  logic [NBW-1:0] nbytes;

  cpm_spi_rx #(.SYNC_W(SYNC_W), .MAXB(MAXB)) u_rx (
    .clk(clk), .rst(rst), .cs_n(spi_cs_n), .sck(spi_sck), .mosi(spi_mosi),
    .cs_low(cs_low), .sck_fall(sck_fall), .cs_end(cs_end), .op_done(op_done),
    .opcode(opcode), .cap(cap), .nbytes(nbytes)
  );

  cpm_cmd_fsm #(.ADDR_W(ADDR_W), .MAXB(MAXB)) u_fsm (
    .clk(clk), .rst(rst), .cs_end(cs_end), .opcode(opcode), .cap(cap),
    .nbytes(nbytes), .wip(st_wip), .prot_base(prot_base), .wel(st_wel),
    .cp(st_cp), .rb_en(st_rb_en), .pgm_valid(pgm_valid), .pgm_addr(pgm_addr),
    .pgm_data(pgm_data)
  );

  cpm_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_busy (
    .clk(clk), .rst(rst), .start(pgm_valid), .busy(st_wip)
  );

  cpm_sdo_drv u_sdo (
    .clk(clk), .rst(rst), .cs_low(cs_low), .sck_fall(sck_fall),
    .op_done(op_done), .opcode(opcode), .wel(st_wel), .wip(st_wip),
    .cp(st_cp), .rb_en(st_rb_en), .miso(spi_miso), .miso_oe(spi_miso_oe)
  );
endmodule

// File: rtl/cpm_ctrl_chk.sv
module cpm_ctrl_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              spi_cs_n,
  input logic              spi_miso_oe,
  input logic [ADDR_W-1:0] prot_base,
  input logic              pgm_valid,
  input logic [ADDR_W-1:0] pgm_addr,
  input logic              st_wel,
  input logic              st_wip,
  input logic              st_cp
);
  a_r2_pair_even: assert property (@(posedge clk) disable iff (rst)
    pgm_valid |-> !pgm_addr[0]);

  a_r4_unprotected_only: assert property (@(posedge clk) disable iff (rst)
    pgm_valid |-> (({1'b0, pgm_addr} + (ADDR_W+1)'(1)) < {1'b0, prot_base}));

  a_r9_busy_follows: assert property (@(posedge clk) disable iff (rst)
    pgm_valid |=> st_wip);

  a_r9_idle_before_pgm: assert property (@(posedge clk) disable iff (rst)
    pgm_valid |-> !st_wip);

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    pgm_valid |=> !pgm_valid);

  a_r6_mode_keeps_wel: assert property (@(posedge clk) disable iff (rst)
    st_cp |-> st_wel);

  a_r11_tristate: assert property (@(posedge clk) disable iff (rst)
    ($past(spi_cs_n, 3) && $past(spi_cs_n, 4) && $past(spi_cs_n, 5)) |-> !spi_miso_oe);
endmodule

bind cpm_ctrl cpm_ctrl_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_miso_oe(spi_miso_oe),
  .prot_base(prot_base), .pgm_valid(pgm_valid), .pgm_addr(pgm_addr),
  .st_wel(st_wel), .st_wip(st_wip), .st_cp(st_cp)
);

// File: tb/test_cpm_ctrl.sv
module test_cpm_ctrl;
  localparam int AW = 24;
  localparam int BUSY = 300;
  localparam int H = 5;

  logic clk = 1'b0, rst = 1'b1, cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic [AW-1:0] prot = 24'h000100;
  logic miso, oe, pv, wel, wip, cp, rb;
  logic [AW-1:0] pa;
  logic [15:0] pd;

  always #2 clk = ~clk;

  cpm_ctrl #(.ADDR_W(AW), .BUSY_CYC(BUSY)) i_cpm_ctrl (
    .clk(clk), .rst(rst), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(oe), .prot_base(prot), .pgm_valid(pv),
    .pgm_addr(pa), .pgm_data(pd), .st_wel(wel), .st_wip(wip), .st_cp(cp),
    .st_rb_en(rb)
  );

  int nvec = 0, nbad = 0, pcnt = 0;
  logic [AW-1:0] last_a = '0;
  logic [15:0] last_d = '0;
  logic [7:0] fb [0:7];
  int m_wel = 0, m_cp = 0, m_rb = 0, m_cur = 0;
  int e_go = 0, e_a = 0, e_d = 0;

  always @(posedge clk) if (pv) begin
    pcnt   <= pcnt + 1;
    last_a <= pa;
    last_d <= pd;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bit_cyc(input logic b, output logic s);
    mosi = b;
    repeat (H) @(negedge clk);
    s = miso;
    sck = 1'b1;
    repeat (H) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic send(input int n);
    logic s;
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < n; i++)
      for (int j = 7; j >= 0; j--) bit_cyc(fb[i][j], s);
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic read_reg(input logic [7:0] op, output logic [7:0] val);
    logic s;
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int j = 7; j >= 0; j--) bit_cyc(op[j], s);
    for (int j = 7; j >= 0; j--) begin
      bit_cyc(1'b0, s);
      val[j] = s;
    end
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int k = 0; k < BUSY + 50 && wip; k++) @(negedge clk);
  endtask

  // Expected effect of one frame on an idle device, from the requirements.
  task automatic model(input int n);
    int a, try_it;
    a = 0; try_it = 0; e_go = 0;
    if (fb[0] == 8'hAD) begin
      if (m_cp == 0) begin
        if (m_wel == 1 && n >= 6) begin
          a = {fb[1], fb[2], fb[3]} & 32'hFFFFFE; e_d = {fb[4], fb[5]}; try_it = 1;
        end
      end else if (n >= 3) begin
        a = m_cur; e_d = {fb[1], fb[2]}; try_it = 1;
      end
      if (try_it == 1 && a + 1 < int'(prot)) begin
        e_go = 1; e_a = a; m_cur = a + 2;
        if (a + 3 >= int'(prot) || a + 3 >= (1 << AW)) begin m_cp = 0; m_wel = 0; end
        else m_cp = 1;
      end
    end else if (fb[0] == 8'h04) begin
      m_wel = 0; m_cp = 0;
    end else if (m_cp == 0) begin
      if (fb[0] == 8'h06) m_wel = 1;
      if (fb[0] == 8'h70) m_rb = 1;
      if (fb[0] == 8'h80) m_rb = 0;
    end
  endtask

  task automatic run(input string tag, input int n, input int idle_after);
    int p0;
    p0 = pcnt;
    model(n);
    send(n);
    chk({tag, " pgm count"}, pcnt - p0, e_go);
    if (e_go == 1) begin
      chk({tag, " pgm addr"}, 32'(last_a), e_a);
      chk({tag, " pgm data"}, 32'(last_d), e_d);
    end
    chk({tag, " wel"}, 32'(wel), m_wel);
    chk({tag, " cp"}, 32'(cp), m_cp);
    chk({tag, " rb"}, 32'(rb), m_rb);
    if (idle_after == 1) wait_idle();
  endtask

  task automatic set1(input logic [7:0] op);
    fb[0] = op;
  endtask

  task automatic set_entry(input logic [23:0] ad, input logic [7:0] d0, input logic [7:0] d1);
    fb[0] = 8'hAD; fb[1] = ad[23:16]; fb[2] = ad[15:8]; fb[3] = ad[7:0];
    fb[4] = d0; fb[5] = d1; fb[6] = 8'h77; fb[7] = 8'h99;
  endtask

  task automatic set_cont(input logic [7:0] d0, input logic [7:0] d1);
    fb[0] = 8'hAD; fb[1] = d0; fb[2] = d1; fb[3] = 8'h5A;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(negedge clk);
    nbad++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    logic [7:0] v;
    int p0, sel, n;
    void'($urandom(32'h00C0FFEE));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 wel", 32'(wel), 0); chk("R1 wip", 32'(wip), 0);
    chk("R1 cp", 32'(cp), 0);   chk("R1 rb", 32'(rb), 0);
    chk("R1 pgm", 32'(pv), 0);  chk("R1 oe", 32'(oe), 0);

    // R2: entry without write-enable is ignored
    set_entry(24'h000011, 8'hA5, 8'h3C); run("R2 no-wel", 6, 1);
    set1(8'h06); run("R2 wren", 1, 1);
    // R2 R3: entry at odd address with extra bytes; R9: continuation while busy ignored
    set_entry(24'h000011, 8'hA5, 8'h3C); run("R2 R3 entry", 8, 0);
    p0 = pcnt; set_cont(8'h11, 8'h22); send(3);
    chk("R9 busy ignored", pcnt - p0, 0);
    wait_idle();
    // R3: one data byte only
    set_cont(8'h44, 8'h55); run("R3 short", 2, 1);
    // R5: next pair
    set_cont(8'hC3, 8'h3C); run("R5 cont", 4, 0);
    // R10: status with wip and wel set
    read_reg(8'h05, v); chk("R10 rdsr busy", 32'(v), 32'h03);
    wait_idle();
    read_reg(8'h2B, v); chk("R10 rdsec mode", 32'(v), 32'h10);
    // R7: refused opcodes in mode
    set1(8'h70); run("R7 rben in mode", 1, 1);
    set1(8'h06); run("R7 wren in mode", 1, 1);
    // R8: write-disable while busy is ignored, then honoured
    set_cont(8'h01, 8'h02); run("R5 cont2", 3, 0);
    set1(8'h04); send(1);
    chk("R8 wrdi busy cp", 32'(cp), 1); chk("R8 wrdi busy wel", 32'(wel), 1);
    wait_idle();
    set1(8'h04); run("R8 wrdi", 1, 1);
    read_reg(8'h2B, v); chk("R10 rdsec idle", 32'(v), 32'h00);
    read_reg(8'h05, v); chk("R10 rdsr idle", 32'(v), 32'h00);

    // R4: protected pair, wel kept
    prot = 24'h000040;
    set1(8'h06); run("R4 wren", 1, 1);
    set_entry(24'h000041, 8'h12, 8'h34); run("R4 protected", 6, 1);
    // R6: last unprotected pair ends the mode
    set_entry(24'h00003C, 8'h12, 8'h34); run("R6 entry", 6, 1);
    set_cont(8'h56, 8'h78); run("R6 last pair", 3, 1);
    set_cont(8'h9A, 8'hBC); run("R6 after exit", 3, 1);

    // R11: ready/busy output
    set1(8'h70); run("R11 rben", 1, 1);
    set1(8'h06); run("R11 wren", 1, 1);
    set_entry(24'h000020, 8'hEE, 8'hDD); run("R11 entry", 6, 0);
    cs_n = 1'b0; repeat (8) @(negedge clk);
    chk("R11 oe busy", 32'(oe), 1); chk("R11 level busy", 32'(miso), 0);
    cs_n = 1'b1; repeat (8) @(negedge clk);
    chk("R11 tristate", 32'(oe), 0);
    wait_idle();
    cs_n = 1'b0; repeat (8) @(negedge clk);
    chk("R11 level ready", 32'(miso), 1);
    cs_n = 1'b1; repeat (8) @(negedge clk);
    set1(8'h80); run("R7 rbdis in mode", 1, 1);
    set1(8'h04); run("R8 wrdi2", 1, 1);
    set1(8'h80); run("R11 rbdis", 1, 1);

    // Random frames against the model (R2 R3 R4 R5 R6 R7 R8)
    prot = 24'h000080;
    for (int it = 0; it < 70; it++) begin
      sel = int'($urandom % 8);
      n = 1;
      case (sel)
        0: set1(8'h06);
        1, 2, 3: begin
          if (m_cp == 1) begin set_cont(8'($urandom), 8'($urandom)); n = 1 + int'($urandom % 4); end
          else begin
            set_entry(24'($urandom % 32'hA0), 8'($urandom), 8'($urandom));
            n = 4 + int'($urandom % 5);
          end
        end
        4: set1(8'h04);
        5: set1(8'h70);
        6: set1(8'h80);
        default: set1(($urandom % 2 == 0) ? 8'h9F : 8'h05);
      endcase
      run("R2-model random", n, 1);
    end
    summary();
  end
endmodule